// File: doc/BRIEF.md
# Registered Command Buffer with Parity

This block is a single register stage that sits on a memory address/command bus between a controller and a row of memory devices. Each rising clock edge samples the command inputs and drives them back out on two identical output banks, so that each bank can feed half of the devices. The clock-enable and termination-control lanes, and the two chip-select lanes, are registered on every edge. The address/command data lanes load only on edges where a command is present, which means at least one chip select is low. On all other edges they keep their previous value.

A configuration input picks which group of data lanes is live. Lanes that are not selected, and three lanes that are never used, drive low. The controller sends an even-parity bit one cycle after each command. The block checks that bit against the data it captured for that command. It reports the combined parity on a partial-parity output. On a mismatch it pulls an active-low error flag for a fixed two-cycle window, which starts two cycles after the check. An asynchronous active-low reset clears every output.

Top module: `cmdbuf_top`

## Requirements
- R1: `cke_i` and `odt_i` are registered on every rising edge, whatever the chip-select state. Each bank copy shows the value sampled at the latest edge.
- R2: The data register loads on an edge where `cs_n_i` is not 2'b11 (at least one select low). On an edge with `cs_n_i` == 2'b11 the data outputs keep their value.
- R3: Both bits of `cs_n_i` are registered on every edge and appear on `cs_na_o` and `cs_nb_o` in the same bit order.
- R4: Bank A and bank B outputs carry identical values on every cycle.
- R5: Lane n (n = 1..14) sits at bit n-1 of `d_i`, `qa_o` and `qb_o`. Lanes 1, 4 and 7 always output 0. With `cfg_i` = 0 the live lanes are 2, 3, 5 and 6. With `cfg_i` = 1 the live lanes are 8 through 14. A lane that is not live loads 0. The mask is applied with the `cfg_i` value seen at the capturing edge.
- R6: On the edge that follows a command edge, `par_i` is sampled. A check fails when the XOR of the captured data outputs and `par_i` is 1 (even parity expected).
- R7: On a check edge `ppo_o` takes that XOR. On any other edge it holds its value.
- R8: After a failed check at edge E, `err_n_o` is low after edges E+2 and E+3 and is high again after E+4. Failures on consecutive checks extend the low window.
- R9: While `rst_ni` is low, all data, chip-select, clock-enable, termination and partial-parity outputs are 0 and `err_n_o` is 1. This takes effect without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 1 | Lane group select: 0 lower, 1 upper |
| cs_n_i | input | 2 | Chip selects, active low |
| d_i | input | 14 | Address/command data lanes |
| cke_i | input | 1 | Clock-enable lane |
| odt_i | input | 1 | Termination-control lane |
| par_i | input | 1 | Parity bit, one cycle after the command |
| qa_o | output | 14 | Data lanes, bank A |
| qb_o | output | 14 | Data lanes, bank B |
| cs_na_o | output | 2 | Registered chip selects, bank A |
| cs_nb_o | output | 2 | Registered chip selects, bank B |
| cke_a_o | output | 1 | Registered clock enable, bank A |
| cke_b_o | output | 1 | Registered clock enable, bank B |
| odt_a_o | output | 1 | Registered termination control, bank A |
| odt_b_o | output | 1 | Registered termination control, bank B |
| ppo_o | output | 1 | Partial parity of the last checked command |
| err_n_o | output | 1 | Parity error flag, active low |

## Verification
The bench runs both configurations through a walking-one pattern across all fourteen data lanes. This shows that every lane maps to the right bit and is either passed or forced low. It then applies a sequence of mixed multi-bit words, which exposes parity arithmetic that only works for single bits. All four chip-select codes are cycled under these words, so that loading can be told apart from holding, and the registered clock-enable and termination lanes are varied on every edge. The parity bit is corrupted on a regular pattern, including back-to-back commands and back-to-back failures, to test the error delay, the window length and its extension. A configuration change during a hold and a reset in the middle of an error window finish the run.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
    // default geometry of the command buffer
    localparam int            DEF_LANES   = 14;
    localparam int            DEF_SPLIT   = 7;        // lanes below this index form the lower group
    localparam logic [13:0]   DEF_UNUSED  = 14'h0049; // lanes 1, 4 and 7 (bits 0, 3, 6)
    localparam int            DEF_DELAY   = 2;        // edges between check and error onset
    localparam int            DEF_STRETCH = 2;        // cycles the error stays low
    localparam int            NUM_CS      = 2;
endpackage

// File: rtl/cmdbuf_capture.sv
module cmdbuf_capture
    import cmdbuf_pkg::*;
#(
    parameter int               LANES  = DEF_LANES,
    parameter int               SPLIT  = DEF_SPLIT,
    parameter logic [LANES-1:0] UNUSED = DEF_UNUSED
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_i,
    input  logic [NUM_CS-1:0] cs_n_i,
    input  logic [LANES-1:0]  d_i,
    input  logic              cke_i,
    input  logic              odt_i,
    output logic [LANES-1:0]  data_o,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic              cke_o,
    output logic              odt_o,
    output logic              cmd_o
);
    typedef struct packed {
        logic [LANES-1:0]  data;
        logic [NUM_CS-1:0] cs_n;
        logic              cke;
        logic              odt;
        logic              cmd;
    } cap_t;

    cap_t             st_d, st_q;
    logic [LANES-1:0] live_mask;
    logic             cmd_now;

    // per-lane enable: lane belongs to the selected group and is not an unused lane
    for (genvar i = 0; i < LANES; i++) begin : g_mask
        if (UNUSED[i]) begin : g_unused
            assign live_mask[i] = 1'b0;
        end else if (i < SPLIT) begin : g_lower
            assign live_mask[i] = ~cfg_i;
        end else begin : g_upper
            assign live_mask[i] = cfg_i;
        end
    end

    assign cmd_now = ~(&cs_n_i);

    always_comb begin
        st_d      = st_q;
        st_d.cs_n = cs_n_i;
        st_d.cke  = cke_i;
        st_d.odt  = odt_i;
        st_d.cmd  = cmd_now;
        if (cmd_now) begin
            st_d.data = d_i & live_mask;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign cs_n_o = st_q.cs_n;
    assign cke_o  = st_q.cke;
    assign odt_o  = st_q.odt;
    assign cmd_o  = st_q.cmd;

    AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&cs_n_i) |=> $stable(data_o)); // R2
    AST_CKE_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (cke_o == $past(cke_i))); // R1
    AST_CS_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (cs_n_o == $past(cs_n_i))); // R3
    AST_UNUSED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_o & UNUSED) == '0); // R5
endmodule

// File: rtl/cmdbuf_parity.sv
module cmdbuf_parity
    import cmdbuf_pkg::*;
#(
    parameter int LANES   = DEF_LANES,
    parameter int DELAY   = DEF_DELAY,
    parameter int STRETCH = DEF_STRETCH
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cmd_i,
    input  logic [LANES-1:0] data_i,
    input  logic             par_i,
    output logic             ppo_o,
    output logic             err_n_o
);
    localparam int CW = $clog2(STRETCH + 1);

    typedef struct packed {
        logic [DELAY-1:0] sh;
        logic [CW-1:0]    cnt;
        logic             ppo;
    } par_t;

    par_t st_d, st_q;
    logic sum;

    assign sum = (^data_i) ^ par_i;

    always_comb begin
        st_d = st_q;
        // delay line: stage 0 is the check result at the sampling edge
        if (DELAY > 1) begin
            st_d.sh = {st_q.sh[DELAY-2:0], 1'b0};
        end else begin
            st_d.sh = '0;
        end
        st_d.sh[0] = cmd_i & sum;
        if (cmd_i) begin
            st_d.ppo = sum;
        end
        // error window: reload on a delayed failure, otherwise count down
        if (st_q.sh[DELAY-1]) begin
            st_d.cnt = CW'(STRETCH);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ppo_o   = st_q.ppo;
    assign err_n_o = (st_q.cnt == '0);

    AST_PPO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_i |=> $stable(ppo_o)); // R7
    AST_ERR_ONSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.sh[DELAY-1] |=> !err_n_o); // R8
    AST_ERR_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(err_n_o) |=> !err_n_o); // R8
    AST_NO_SPURIOUS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cmd_i && err_n_o && (st_q.sh == '0)) |=> (st_q.sh[0] == 1'b0)); // R6
endmodule

// File: rtl/cmdbuf_fanout.sv
module cmdbuf_fanout #(
    parameter int W = 18
) (
    input  logic [W-1:0] src_i,
    output logic [W-1:0] bank_a_o,
    output logic [W-1:0] bank_b_o
);
    for (genvar i = 0; i < W; i++) begin : g_dup
        assign bank_a_o[i] = src_i[i];
        assign bank_b_o[i] = src_i[i];
    end
endmodule

// File: rtl/cmdbuf_top.sv
module cmdbuf_top
    import cmdbuf_pkg::*;
#(
    parameter int               LANES   = DEF_LANES,
    parameter int               SPLIT   = DEF_SPLIT,
    parameter logic [LANES-1:0] UNUSED  = DEF_UNUSED,
    parameter int               DELAY   = DEF_DELAY,
    parameter int               STRETCH = DEF_STRETCH
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_i,
    input  logic [NUM_CS-1:0] cs_n_i,
    input  logic [LANES-1:0]  d_i,
    input  logic              cke_i,
    input  logic              odt_i,
    input  logic              par_i,
    output logic [LANES-1:0]  qa_o,
    output logic [LANES-1:0]  qb_o,
    output logic [NUM_CS-1:0] cs_na_o,
    output logic [NUM_CS-1:0] cs_nb_o,
    output logic              cke_a_o,
    output logic              cke_b_o,
    output logic              odt_a_o,
    output logic              odt_b_o,
    output logic              ppo_o,
    output logic              err_n_o
);
    localparam int FW = LANES + NUM_CS + 2;

    logic [LANES-1:0]  data_q;
    logic [NUM_CS-1:0] cs_q;
    logic              cke_q, odt_q, cmd_q;
    logic [FW-1:0]     fan_src, fan_a, fan_b;

    cmdbuf_capture #(.LANES(LANES), .SPLIT(SPLIT), .UNUSED(UNUSED)) cap_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cfg_i  (cfg_i),
        .cs_n_i (cs_n_i),
        .d_i    (d_i),
        .cke_i  (cke_i),
        .odt_i  (odt_i),
        .data_o (data_q),
        .cs_n_o (cs_q),
        .cke_o  (cke_q),
        .odt_o  (odt_q),
        .cmd_o  (cmd_q)
    );

    cmdbuf_parity #(.LANES(LANES), .DELAY(DELAY), .STRETCH(STRETCH)) par_chk_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cmd_i   (cmd_q),
        .data_i  (data_q),
        .par_i   (par_i),
        .ppo_o   (ppo_o),
        .err_n_o (err_n_o)
    );

    assign fan_src = {data_q, cs_q, cke_q, odt_q};

    cmdbuf_fanout #(.W(FW)) fan_i (
        .src_i    (fan_src),
        .bank_a_o (fan_a),
        .bank_b_o (fan_b)
    );

    assign {qa_o, cs_na_o, cke_a_o, odt_a_o} = fan_a;
    assign {qb_o, cs_nb_o, cke_b_o, odt_b_o} = fan_b;

    AST_BANK_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (qa_o == qb_o) && (cs_na_o == cs_nb_o) && (cke_a_o == cke_b_o) && (odt_a_o == odt_b_o)); // R4
endmodule

// File: tb/cmdbuf_top_tb.sv
module cmdbuf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg = 1'b0;
    logic [1:0]  cs_n = 2'b11;
    logic [13:0] d = '0;
    logic        cke = 1'b0, odt = 1'b0, par = 1'b0;
    logic [13:0] qa, qb;
    logic [1:0]  csa, csb;
    logic        ckea, ckeb, odta, odtb, ppo, err_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model state
    logic [13:0] m_data;
    logic [1:0]  m_cs;
    logic        m_cke, m_odt, m_valid, m_ppo;
    logic        f1, f2, f3, f4;

    always #10 clk = ~clk;

    cmdbuf_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .cs_n_i(cs_n), .d_i(d),
        .cke_i(cke), .odt_i(odt), .par_i(par),
        .qa_o(qa), .qb_o(qb), .cs_na_o(csa), .cs_nb_o(csb),
        .cke_a_o(ckea), .cke_b_o(ckeb), .odt_a_o(odta), .odt_b_o(odtb),
        .ppo_o(ppo), .err_n_o(err_n)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [13:0] lane_mask(input logic c);
        logic [13:0] m = '0;
        for (int n = 1; n <= 14; n++) begin
            if (n != 1 && n != 4 && n != 7) m[n-1] = c ? (n >= 8) : (n <= 7);
        end
        return m;
    endfunction

    task automatic model_reset();
        m_data = '0; m_cs = '0; m_cke = 0; m_odt = 0; m_valid = 0; m_ppo = 0;
        f1 = 0; f2 = 0; f3 = 0; f4 = 0;
    endtask

    task automatic compare_all();
        logic exp_err_n;
        exp_err_n = !(f3 || f4);
        check(qa == m_data, "R2 R5 bank A data", 16'(qa), 16'(m_data));
        check(qb == m_data, "R4 bank B data", 16'(qb), 16'(m_data));
        check(csa == m_cs, "R3 bank A selects", 16'(csa), 16'(m_cs));
        check(csb == m_cs, "R3 R4 bank B selects", 16'(csb), 16'(m_cs));
        check(ckea == m_cke && ckeb == m_cke, "R1 clock enable", 16'({ckea, ckeb}), 16'({m_cke, m_cke}));
        check(odta == m_odt && odtb == m_odt, "R1 termination", 16'({odta, odtb}), 16'({m_odt, m_odt}));
        check(ppo == m_ppo, "R7 partial parity", 16'(ppo), 16'(m_ppo));
        check(err_n == exp_err_n, "R6 R8 error flag", 16'(err_n), 16'(exp_err_n));
    endtask

    // one clock: drive at falling edge, model the rising edge, compare after it
    task automatic cyc(input logic [1:0] c, input logic [13:0] dv, input logic k,
                       input logic o, input logic cf, input bit inject);
        logic fail;
        @(negedge clk);
        cs_n = c; d = dv; cke = k; odt = o; cfg = cf;
        par  = (m_valid ? ^m_data : 1'b0) ^ inject;
        @(posedge clk);
        #2;
        fail = 1'b0;
        if (m_valid) begin
            m_ppo = (^m_data) ^ par;
            fail  = m_ppo;
        end
        f4 = f3; f3 = f2; f2 = f1; f1 = fail;
        m_valid = (c != 2'b11);
        if (m_valid) m_data = dv & lane_mask(cf);
        m_cs = c; m_cke = k; m_odt = o;
        compare_all();
    endtask

    task automatic check_reset_state(input string tag);
        check(qa == '0 && qb == '0, {tag, " R9 data"}, 16'(qa | qb), 16'h0);
        check(csa == '0 && csb == '0 && !ckea && !ckeb && !odta && !odtb,
              {tag, " R9 control"}, 16'({csa, csb, ckea, ckeb, odta, odtb}), 16'h0);
        check(ppo == 1'b0 && err_n == 1'b1, {tag, " R9 parity flags"}, 16'({ppo, err_n}), 16'h1);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        check_reset_state("initial");
        @(negedge clk);
        rst_n = 1'b1;

        // sweep: walking ones then mixed words, both configurations, all select codes
        for (int cf = 0; cf < 2; cf++) begin
            for (int k = 0; k < 40; k++) begin
                logic [13:0] w;
                w = (k < 14) ? (14'h1 << k) : 14'((k * 16'h2B5 + 16'h137) ^ (k << 9));
                cyc(2'(k % 4), w, k[0], k[1] ^ k[2], cf[0], (k % 5) == 2);
            end
        end

        // back-to-back commands with consecutive parity failures
        for (int k = 0; k < 6; k++) cyc(2'b00, 14'h3FFF ^ 14'(k * 37), 1'b1, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 6; k++) cyc(2'b11, 14'h0, 1'b0, 1'b1, 1'b1, 1'b0);

        // configuration change while holding: data must not move
        cyc(2'b10, 14'h3FFF, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(2'b11, 14'h1234, 1'b1, 1'b1, 1'b1, 1'b0);
        cyc(2'b11, 14'h2AAA, 1'b0, 1'b1, 1'b1, 1'b0);
        cyc(2'b01, 14'h3FFF, 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(2'b11, 14'h0, 1'b0, 1'b0, 1'b1, 1'b0);

        // reset inside an error window
        cyc(2'b00, 14'h0F0F, 1'b1, 1'b1, 1'b0, 1'b0);
        cyc(2'b11, 14'h0, 1'b1, 1'b1, 1'b0, 1'b1);
        cyc(2'b11, 14'h0, 1'b1, 1'b1, 1'b0, 1'b0);
        cyc(2'b11, 14'h0, 1'b1, 1'b1, 1'b0, 1'b0);
        check(err_n == 1'b0, "R8 error active before reset", 16'(err_n), 16'h0);
        @(negedge clk);
        #5;
        rst_n = 1'b0;
        #1;
        check_reset_state("async");
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        cyc(2'b11, 14'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(2'b11, 14'h0, 1'b0, 1'b0, 1'b0, 1'b0);

        finish_up();
    end
endmodule